// File: doc/BRIEF.md
# Sticky Floating-Point Status Register

This block holds the floating-point status word of an execution core. The word is 64 bits wide. It collects six exception flags and one integer-saturation flag. Each of these flags is sticky: once set, it stays at 1 until software clears it. The word also carries four comparison condition flags. In every cycle the execution units may pulse one event line per exception class and one saturation line. A control word gives one trap-enable bit for each exception class. An event sets its flag only while the matching trap-enable bit is clear. When trapping is enabled, the trap handler is responsible for recording the event, so the hardware leaves the flag alone.

Software replaces all writable fields through a full-word write port. The condition flags can also be loaded as a group through a separate update strobe, which a comparison unit uses. The read port always returns the whole word, and every reserved bit reads as zero. All state changes at the rising clock edge. The read value is driven straight from the stored state, so an update shows on the read port one cycle after it is presented.

Top module: `fpstat_reg`

## Requirements
- R1: A synchronous active-high reset clears every field, so the read port returns 0 in the cycle after reset is applied.
- R2: Bits 63:32, 26:8 and 6:5 always read as 0. Writing 1s to them leaves them at 0, so a write of all ones reads back as 0x00000000F800009F.
- R3: A software write replaces every writable field with the written value. This includes setting any sticky flag to 1 whatever the trap-enable bits are, and clearing any flag to 0.
- R4: Event line i of `exc_evt` maps to a flag position as follows: i=0 to bit 0 (invalid operation), i=1 to bit 1 (divide by zero), i=2 to bit 2 (overflow), i=3 to bit 3 (underflow), i=4 to bit 4 (inexact), i=5 to bit 7 (input denormal). An event with `trap_en[i]`=0 sets that flag to 1 at the next edge.
- R5: An event with `trap_en[i]`=1 leaves its flag unchanged.
- R6: An exception flag that is at 1 stays at 1 until a software write puts 0 in that bit.
- R7: A pulse on `sat_evt` sets bit 27 to 1. Bit 27 then stays at 1 until software writes 0 to it. No trap-enable bit gates it.
- R8: When a software write and an enabled event (or a saturation event) reach the same flag in the same cycle, the flag takes the written bit ORed with the event, so the event is never lost.
- R9: With `cmp_en`=1 and no software write, bits 31:28 load `cmp_flags`. `cmp_flags[3]` goes to bit 31 (negative), `[2]` to bit 30 (zero), `[1]` to bit 29 (carry) and `[0]` to bit 28 (overflow). With `cmp_en`=0 these bits hold.
- R10: A software write in the same cycle as `cmp_en` wins, and bits 31:28 take `wr_data[31:28]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 64 | Software write value |
| exc_evt | input | 6 | Exception event pulses, index mapping as in R4 |
| trap_en | input | 6 | Per-exception trap enables, same indexing as `exc_evt` |
| sat_evt | input | 1 | Integer saturation event pulse |
| cmp_en | input | 1 | Condition flag update strobe |
| cmp_flags | input | 4 | New condition flags: negative, zero, carry, overflow from bit 3 down |
| rd_data | output | 64 | Current status word, reserved bits zero |

## Verification
The assertions assume that reset is held through the first clock edge, so the state is defined before any property is enabled. They also assume that `wr_en`, the event lines and `cmp_en` are never unknown once reset is released. The bench meets both conditions: it drives every input to a known value at time zero and holds reset for several cycles. It then changes inputs only just after a rising edge. In the main sweep, every combination of the six trap enables is paired with every combination of the six event lines. Each trap setting starts from a cleared word, and the flags are left to accumulate across the event patterns. This covers the sticky, gated and ungated paths on every flag position.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;

    localparam int REG_W   = 64;
    localparam int N_EXC   = 6;
    localparam int N_CMP   = 4;
    localparam int SAT_POS = 27;
    localparam int CMP_LSB = 28;

    // Bits that hold state; every other bit reads as zero.
    localparam logic [REG_W-1:0] LIVE_MASK = 64'h0000_0000_F800_009F;

    // Bit position of exception flag i (index order fixed by the event bus).
    function automatic int exc_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            3:       return 3;
            4:       return 4;
            default: return 7;
        endcase
    endfunction

    typedef struct packed {
        logic [N_CMP-1:0] cond;
        logic             sat;
        logic [N_EXC-1:0] exc;
    } fpstat_state_t;

endpackage

// File: rtl/fpstat_flag_cell.sv
module fpstat_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic evt,
    input  logic trap,
    output logic q
);

    logic hw_set;
    logic q_nxt;

    assign hw_set = evt & ~trap;

    always_comb begin
        if (wr_en) q_nxt = wr_bit | hw_set;
        else       q_nxt = q | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= q_nxt;
    end

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (q && !wr_en) |=> q);

    // R5
    trap_block_chk: assert property (@(posedge clk) disable iff (rst)
        (!q && !wr_en && trap) |=> !q);

    // R8
    coincident_or_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && evt && !trap) |=> q);

endmodule

// File: rtl/fpstat_cond_group.sv
module fpstat_cond_group #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         upd_en,
    input  logic [W-1:0] upd_val,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (wr_en)  q <= wr_val;
        else if (upd_en) q <= upd_val;
    end

    // R10
    wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q == $past(wr_val)));

    // R9
    cmp_load_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !wr_en) |=> (q == $past(upd_val)));

    // R9
    cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!upd_en && !wr_en) |=> $stable(q));

endmodule

// File: rtl/fpstat_reg.sv
module fpstat_reg
    import fpstat_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [N_EXC-1:0]   exc_evt,
    input  logic [N_EXC-1:0]   trap_en,
    input  logic               sat_evt,
    input  logic               cmp_en,
    input  logic [N_CMP-1:0]   cmp_flags,
    output logic [REG_W-1:0]   rd_data
);

    fpstat_state_t st;

    logic unused_rsv;
    assign unused_rsv = ^(wr_data & ~LIVE_MASK);

    for (genvar g = 0; g < N_EXC; g++) begin : g_exc
        fpstat_flag_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_en),
            .wr_bit (wr_data[exc_pos(g)]),
            .evt    (exc_evt[g]),
            .trap   (trap_en[g]),
            .q      (st.exc[g])
        );
    end

    fpstat_flag_cell u_sat (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_bit (wr_data[SAT_POS]),
        .evt    (sat_evt),
        .trap   (1'b0),
        .q      (st.sat)
    );

    fpstat_cond_group #(.W(N_CMP)) u_cond (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_val  (wr_data[CMP_LSB +: N_CMP]),
        .upd_en  (cmp_en),
        .upd_val (cmp_flags),
        .q       (st.cond)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_EXC; i++) rd_data[exc_pos(i)] = st.exc[i];
        rd_data[SAT_POS]             = st.sat;
        rd_data[CMP_LSB +: N_CMP]    = st.cond;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

    // R7
    sat_set_chk: assert property (@(posedge clk) disable iff (rst)
        sat_evt |=> rd_data[SAT_POS]);

    // R4
    exc_set_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_evt[0] && !trap_en[0]) |=> rd_data[0]);

endmodule

// File: tb/fpstat_reg_tb_top.sv
module fpstat_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [5:0]  exc_evt = '0;
    logic [5:0]  trap_en = '0;
    logic        sat_evt = 1'b0;
    logic        cmp_en = 1'b0;
    logic [3:0]  cmp_flags = '0;
    logic [63:0] rd_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [63:0] model = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fpstat_reg dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .exc_evt(exc_evt), .trap_en(trap_en), .sat_evt(sat_evt),
        .cmp_en(cmp_en), .cmp_flags(cmp_flags), .rd_data(rd_data)
    );

    function automatic int pos_of(input int i);
        return (i == 5) ? 7 : i;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, compare after the edge.
    task automatic step(input string tag, input bit w, input logic [63:0] wd,
                        input logic [5:0] ev, input logic [5:0] tr, input bit sat,
                        input bit ce, input logic [3:0] cf);
        logic [63:0] nx;
        wr_en = w; wr_data = wd; exc_evt = ev; trap_en = tr;
        sat_evt = sat; cmp_en = ce; cmp_flags = cf;
        nx = '0;
        for (int i = 0; i < 6; i++)
            nx[pos_of(i)] = (w ? wd[pos_of(i)] : model[pos_of(i)]) | (ev[i] & ~tr[i]);
        nx[27] = (w ? wd[27] : model[27]) | sat;
        nx[31:28] = w ? wd[31:28] : (ce ? cf : model[31:28]);
        model = nx;
        @(posedge clk); #1;
        check(tag, rd_data, model);
        wr_en = 1'b0; exc_evt = '0; sat_evt = 1'b0; cmp_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        check("R1 reset", rd_data, 64'h0);

        // R2 R3: write all ones, reserved stays zero, trap enables do not block writes
        step("R2 R3 write ones", 1, '1, 6'h0, 6'h3F, 0, 0, 4'h0);
        check("R2 reserved zero", rd_data & ~64'h0000_0000_F800_009F, 64'h0);
        check("R2 readback", rd_data, 64'h0000_0000_F800_009F);
        // R6: flags hold without writes, even with all traps on
        step("R6 hold", 0, '0, 6'h3F, 6'h3F, 0, 0, 4'h0);
        // R3: clear everything
        step("R3 clear", 1, 64'hFFFF_FFFF_07FF_FF60, 6'h0, 6'h0, 0, 0, 4'h0);
        check("R3 cleared", rd_data, 64'h0);

        // R4 R5 R6: sweep all trap masks against all event patterns
        for (int t = 0; t < 64; t++) begin
            step("R3 sweep clear", 1, '0, 6'h0, 6'h0, 0, 0, 4'h0);
            for (int e = 0; e < 64; e++)
                step("R4 R5 R6 sweep", 0, '0, e[5:0], t[5:0], 0, 0, 4'h0);
        end

        // R4: single enabled event per line
        for (int i = 0; i < 6; i++) begin
            step("R4 clear", 1, '0, 6'h0, 6'h0, 0, 0, 4'h0);
            step("R4 single", 0, '0, 6'(1 << i), 6'h0, 0, 0, 4'h0);
            check("R4 position", rd_data, 64'(1) << pos_of(i));
        end

        // R7: saturation sticky, cleared only by write of 0
        step("R7 set", 0, '0, 6'h0, 6'h0, 1, 0, 4'h0);
        check("R7 bit27", {63'h0, rd_data[27]}, 64'h1);
        step("R7 hold", 0, '0, 6'h0, 6'h3F, 0, 0, 4'h0);
        step("R7 clear", 1, '0, 6'h0, 6'h0, 0, 0, 4'h0);

        // R8: write of 0 coincident with events keeps the events
        step("R8 or", 1, '0, 6'h3F, 6'h0, 1, 0, 4'h0);
        check("R8 value", rd_data, 64'h0000_0000_0800_009F);
        step("R8 trapped", 1, '0, 6'h3F, 6'h2A, 0, 0, 4'h0);

        // R9: condition flag loads, every value
        for (int c = 0; c < 16; c++)
            step("R9 load", 0, '0, 6'h0, 6'h0, 0, 1, c[3:0]);
        step("R9 n only", 0, '0, 6'h0, 6'h0, 0, 1, 4'b1000);
        check("R9 bit31", rd_data & 64'hF000_0000, 64'h8000_0000);
        step("R9 hold", 0, '0, 6'h0, 6'h0, 0, 0, 4'b0001);

        // R10: write beats condition update
        step("R10 prio", 1, 64'h0000_0000_5000_0000, 6'h0, 6'h0, 0, 1, 4'b1010);
        check("R10 value", rd_data & 64'hF000_0000, 64'h5000_0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule